// File: doc/BRIEF.md
# Configurable Logic Cell

This block is one programmable logic element of a fabric. A four-input lookup table computes any Boolean function of the four data inputs. A storage element registers either the table result or a direct data input. That storage element acts as a rising-edge flip-flop or as a latch that is open while the clock is high. A separate pass-through output copies the direct input, so the table, the storage element and the pass-through path can all be used at the same time.

A carry stage sits next to the table. In arithmetic use, neighbouring cells chain their carry-in and carry-out pins to form a ripple adder. A mode bit turns the same chain into a cascade that ANDs or ORs the table result of each cell into the chain, which builds very wide decoders. A single configuration word holds the truth table and the mode bits. It is written through a load-enable port while the cell is idle.

Top module: `cfg_logic_cell`

## Requirements
- R1: With the sum bit (config bit 20) clear, `x_out` equals truth-table bit number {f_in[3],f_in[2],f_in[1],f_in[0]}, where the truth table is config bits 15:0 and f_in[0] is the index LSB.
- R2: With the sum bit set, `x_out` equals the selected truth-table bit XOR `ci`. With the table set to 16'h6666, this gives f_in[0] XOR f_in[1] XOR ci.
- R3: With the cascade-enable bit (config bit 18) clear, `co` is the majority of f_in[0], f_in[1] and `ci`.
- R4: With cascade enabled and the cascade-OR bit (config bit 19) clear, `co` is `ci` AND the selected truth-table bit.
- R5: With cascade enabled and the cascade-OR bit set, `co` is `ci` OR the selected truth-table bit.
- R6: `do_out` follows `di` combinationally at all times, in every mode.
- R7: With the latch bit (config bit 16) clear, a rising `clk` edge with `ce` high and `clr` low loads the storage data into `q_out`.
- R8: With `ce` low, a rising `clk` edge leaves `q_out` unchanged.
- R9: The data-select bit (config bit 17) picks the storage data: `x_out` when 0, `di` when 1.
- R10: With the latch bit set and `ce` high, `q_out` follows the storage data while `clk` is high and holds its value while `clk` is low.
- R11: `clr` high forces `q_out` to 0 at once, without a clock, in both flip-flop and latch mode.
- R12: `cfg_we` high at a rising `clk` edge stores `cfg_word`. `rst_n` low clears the stored word to all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration register and the storage element |
| rst_n | input | 1 | Asynchronous active-low reset of the configuration word |
| cfg_we | input | 1 | Load enable for the configuration word |
| cfg_word | input | 21 | Configuration: truth table [15:0], latch [16], data select [17], cascade enable [18], cascade OR [19], sum [20] |
| f_in | input | 4 | Function inputs of the lookup table |
| di | input | 1 | Direct data input |
| ce | input | 1 | Clock enable of the storage element |
| clr | input | 1 | Asynchronous active-high clear of the storage element |
| ci | input | 1 | Carry or cascade input |
| x_out | output | 1 | Combinational function output |
| q_out | output | 1 | Storage element output |
| do_out | output | 1 | Direct pass-through output |
| co | output | 1 | Carry or cascade output |

## Verification
A wrong stored configuration bit shows up in the same cycle as a wrong `x_out` or `co` for some input pattern. For this reason the combinational table walk reloads the configuration before each vector and samples one nanosecond after the inputs settle. A corrupt storage state shows on `q_out` one clock edge after the capture, or, in latch mode, within the high phase of that clock. The directed tests therefore read `q_out` on the falling edge after each capture, hold or clear. Clear is checked before any further edge, so a clear that waits for a clock is reported at once.

// File: rtl/lc_pkg.sv
package lc_pkg;
    localparam int LC_K    = 4;
    localparam int LC_TT_W = 1 << LC_K;
    localparam int LC_CFG_W = LC_TT_W + 5;

    typedef struct packed {
        logic               sum_en;
        logic               casc_or;
        logic               casc_en;
        logic               d_sel;
        logic               latch_mode;
        logic [LC_TT_W-1:0] truth;
    } cell_cfg_t;
endpackage

// File: rtl/lc_lut.sv
module lc_lut #(
    parameter int K = 4,
    localparam int TT_W = 1 << K
) (
    input  logic [TT_W-1:0] truth,
    input  logic [K-1:0]    sel,
    output logic            y
);
    logic [TT_W-1:0] stage_mask;

    generate
        for (genvar i = 0; i < TT_W; i++) begin : g_dec
            assign stage_mask[i] = (sel == K'(i)) & truth[i];
        end
    endgenerate

    always_comb begin
        y = |stage_mask;
    end
endmodule

// File: rtl/lc_carry.sv
module lc_carry (
    input  logic a,
    input  logic b,
    input  logic cin,
    input  logic lut_y,
    input  logic casc_en,
    input  logic casc_or,
    output logic cout
);
    logic maj_c;
    logic chain_c;

    always_comb begin
        maj_c   = (a & b) | (a & cin) | (b & cin);
        chain_c = casc_or ? (cin | lut_y) : (cin & lut_y);
        cout    = casc_en ? chain_c : maj_c;
    end
endmodule

// File: rtl/lc_store.sv
module lc_store (
    input  logic clk,
    input  logic clr,
    input  logic ce,
    input  logic latch_mode,
    input  logic d,
    output logic q
);
    logic ff_d, ff_q;
    logic lat_q;

    always_comb begin
        ff_d = ce ? d : ff_q;
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) ff_q <= 1'b0;
        else     ff_q <= ff_d;
    end

    always_latch begin
        if (clr)             lat_q = 1'b0;
        else if (clk && ce)  lat_q = d;
    end

    always_comb begin
        q = latch_mode ? lat_q : ff_q;
    end
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
    import lc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [LC_CFG_W-1:0] cfg_word,
    input  logic [LC_K-1:0]     f_in,
    input  logic                di,
    input  logic                ce,
    input  logic                clr,
    input  logic                ci,
    output logic                x_out,
    output logic                q_out,
    output logic                do_out,
    output logic                co
);
    cell_cfg_t cfg_d, cfg_q;
    logic lut_y;
    logic st_data;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) cfg_d = cell_cfg_t'(cfg_word);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    lc_lut #(.K(LC_K)) u_lut (
        .truth (cfg_q.truth),
        .sel   (f_in),
        .y     (lut_y)
    );

    lc_carry u_carry (
        .a       (f_in[0]),
        .b       (f_in[1]),
        .cin     (ci),
        .lut_y   (lut_y),
        .casc_en (cfg_q.casc_en),
        .casc_or (cfg_q.casc_or),
        .cout    (co)
    );

    always_comb begin
        x_out   = lut_y ^ (cfg_q.sum_en & ci);
        st_data = cfg_q.d_sel ? di : x_out;
        do_out  = di;
    end

    lc_store u_store (
        .clk        (clk),
        .clr        (clr),
        .ce         (ce),
        .latch_mode (cfg_q.latch_mode),
        .d          (st_data),
        .q          (q_out)
    );
endmodule

// File: rtl/lc_checker.sv
module lc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [20:0] cfg_cur,
    input logic [3:0]  f_in,
    input logic        di,
    input logic        ce,
    input logic        clr,
    input logic        ci,
    input logic        x_out,
    input logic        q_out,
    input logic        co
);
    logic latch_m, dsel_m, casc_m, or_m, sum_m;
    assign latch_m = cfg_cur[16];
    assign dsel_m  = cfg_cur[17];
    assign casc_m  = cfg_cur[18];
    assign or_m    = cfg_cur[19];
    assign sum_m   = cfg_cur[20];

    // R11: clear dominates storage output
    assert_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> (q_out == 1'b0));

    // R7, R9: flip-flop capture of selected data
    assert_ff_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_m && ce && !clr && !cfg_we) |=>
        (clr || q_out == $past(dsel_m ? di : x_out)));

    // R8: hold with clock enable low
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_m && !ce && !clr && !cfg_we) |=> (clr || $stable(q_out)));

    // R2, R3: adder identity in sum mode
    assert_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_m && !casc_m && cfg_cur[15:0] == 16'h6666) |->
        ({co, x_out} == 2'(f_in[0]) + 2'(f_in[1]) + 2'(ci)));

    // R4: AND cascade never raises co without ci
    assert_casc_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (casc_m && !or_m && co) |-> ci);

    // R5: OR cascade passes an active ci through
    assert_casc_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (casc_m && or_m && ci) |-> co);
endmodule

bind cfg_logic_cell lc_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_cur (cfg_q),
    .f_in    (f_in),
    .di      (di),
    .ce      (ce),
    .clr     (clr),
    .ci      (ci),
    .x_out   (x_out),
    .q_out   (q_out),
    .co      (co)
);

// File: tb/sim_cfg_logic_cell.sv
`timescale 1ns/1ps
module sim_cfg_logic_cell;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [20:0] cfg_word = '0;
    logic [3:0]  f_in = '0;
    logic        di = 1'b0, ce = 1'b0, clr = 1'b1, ci = 1'b0;
    logic        x_out, q_out, do_out, co;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cfg_logic_cell u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .f_in(f_in), .di(di), .ce(ce), .clr(clr), .ci(ci),
        .x_out(x_out), .q_out(q_out), .do_out(do_out), .co(co)
    );

    // stimulus: {config, f, di, ci}
    localparam int NV = 12;
    localparam logic [26:0] VEC [NV] = '{
        {21'h106666, 4'b0001, 1'b0, 1'b0},
        {21'h106666, 4'b0011, 1'b1, 1'b1},
        {21'h106666, 4'b0010, 1'b0, 1'b1},
        {21'h008000, 4'b1111, 1'b1, 1'b0},
        {21'h008000, 4'b0111, 1'b0, 1'b1},
        {21'h048000, 4'b1111, 1'b0, 1'b1},
        {21'h048000, 4'b1111, 1'b0, 1'b0},
        {21'h048000, 4'b1110, 1'b1, 1'b1},
        {21'h0CFFFE, 4'b0000, 1'b0, 1'b0},
        {21'h0CFFFE, 4'b0000, 1'b1, 1'b1},
        {21'h0CFFFE, 4'b0101, 1'b0, 1'b0},
        {21'h00A5C3, 4'b1001, 1'b1, 1'b0}
    };

    task automatic check(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic ref_x(input logic [20:0] c, input logic [3:0] f, input logic cin);
        return c[f] ^ (c[20] & cin);
    endfunction

    function automatic logic ref_co(input logic [20:0] c, input logic [3:0] f, input logic cin);
        logic t = c[f];
        if (!c[18]) return (f[0] & f[1]) | (f[0] & cin) | (f[1] & cin);
        return c[19] ? (cin | t) : (cin & t);
    endfunction

    task automatic load_cfg(input logic [20:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_word = w;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        // reset: config cleared, storage cleared
        repeat (3) @(negedge clk);
        f_in = 4'b1111;
        #1;
        check(x_out, 1'b0, "R12 reset truth table zero");
        check(q_out, 1'b0, "R11 clear during reset");
        rst_n = 1'b1;
        @(negedge clk);
        clr = 1'b0;

        // combinational table walk: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            logic [20:0] c = VEC[i][26:6];
            load_cfg(c);
            f_in = VEC[i][5:2]; di = VEC[i][1]; ci = VEC[i][0];
            #1;
            check(x_out, ref_x(c, VEC[i][5:2], VEC[i][0]), "R1/R2 x_out");
            check(co, ref_co(c, VEC[i][5:2], VEC[i][0]), "R3/R4/R5 co");
            check(do_out, VEC[i][1], "R6 do_out");
        end

        // flip-flop capture of x (R7, R9 select 0)
        ci = 1'b0;
        load_cfg(21'h00FFFF);
        ce = 1'b1; di = 1'b0;
        @(negedge clk); #1;
        check(q_out, 1'b1, "R7 capture x");
        check(do_out, 1'b0, "R6 feedthrough alongside storage");
        // hold with ce low even though x changes (R8)
        ce = 1'b0;
        load_cfg(21'h000000);
        @(negedge clk); #1;
        check(q_out, 1'b1, "R8 hold with ce low");
        // async clear without clock (R11)
        @(negedge clk);
        clr = 1'b1; #1;
        check(q_out, 1'b0, "R11 async clear ff");
        @(negedge clk);
        clr = 1'b0;
        // data select DI (R9)
        load_cfg(21'h020000);
        ce = 1'b1; di = 1'b1;
        @(negedge clk); #1;
        check(x_out, 1'b0, "R9 x low while di stored");
        check(q_out, 1'b1, "R9 capture di");

        // latch mode, data from di (R10)
        load_cfg(21'h030000);
        @(posedge clk); #1;
        di = 1'b0; #1;
        check(q_out, 1'b0, "R10 transparent low");
        di = 1'b1; #1;
        check(q_out, 1'b1, "R10 transparent high");
        @(negedge clk); #1;
        di = 1'b0; #1;
        check(q_out, 1'b1, "R10 hold while clk low");
        @(posedge clk); #1;
        check(q_out, 1'b0, "R10 follows on high phase");
        di = 1'b1; #1;
        clr = 1'b1; #1;
        check(q_out, 1'b0, "R11 clear in latch mode");
        @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule